// File: doc/BRIEF.md
# Supply Droop Filter and Non-Maskable Interrupt Merge

This block turns a raw "supply is below threshold" comparator level into a clean, debounced event. The comparator output reaches the block already synchronised to the system clock. A free-running prescaler produces a sample strobe at one of four selectable rates. A run-length filter samples the comparator on each strobe and changes its output level only after a run of agreeing samples. When the filtered level falls, a sticky "droop seen" flag is set. If interrupts are enabled, the block also emits a single-cycle interrupt request.

That request is merged with a watchdog request and an oscillator-fail request into one registered non-maskable interrupt line. Software drives the detector enable, the interrupt enable, the 2-bit sample-rate select and a clear strobe for the flag. The prescaler never stops, so detection keeps working while the processor sleeps.

Top module: `lvd_nmi_top`

## Requirements
- R1: The sample strobe repeats every 8, 16, 32 or 64 clocks for `rate_sel` = 0, 1, 2 and 3. It keeps running whatever the enable state is. Pulling `sup_ok` low makes `lvd_flag` rise between 3×P and 4×P+4 clocks later, where P is the strobe period.
- R2: The filtered level `lvd_level` goes to 0 only after 4 consecutive strobes sample `sup_ok`=0. It returns to 1 only after 4 consecutive strobes sample `sup_ok`=1. A low lasting fewer than 4 samples leaves the level at 1 and the flag at 0.
- R3: While `det_on`=0, `lvd_level` is held at 1 and `lvd_flag` is 0 from the next clock on. A low `sup_ok` then sets nothing.
- R4: A falling edge of the filtered level sets `lvd_flag` while `det_on`=1. The flag stays at 1 after the supply recovers.
- R5: A high `flag_clr` clears `lvd_flag` on the next clock. After that, a new droop sets the flag and requests an interrupt again.
- R6: When `lvd_flag` goes from 0 to 1 and `irq_on`=1, `lvd_irq` is high for exactly one clock. When `irq_on`=0, the flag still sets but no request is made.
- R7: While `lvd_flag`=1, further droops produce no `lvd_irq` and no `nmi`.
- R8: When a clear and a new detection fall in the same clock, the clear wins. The flag ends at 0 and no request is issued.
- R9: `nmi` is high one clock after any of `lvd_irq`, `wdt_req` or `osc_req` is high.
- R10: After reset, `lvd_level`=1, `lvd_flag`=0, `lvd_irq`=0 and `nmi`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| det_on | input | 1 | Detector enable |
| irq_on | input | 1 | Droop interrupt enable |
| rate_sel | input | 2 | Sample strobe rate select (0: /8, 1: /16, 2: /32, 3: /64) |
| flag_clr | input | 1 | Software clear of the droop flag |
| sup_ok | input | 1 | Synchronised comparator output, 1 = supply above threshold |
| wdt_req | input | 1 | Watchdog interrupt request |
| osc_req | input | 1 | Oscillator-fail interrupt request |
| lvd_level | output | 1 | Filtered supply level, 1 = healthy |
| lvd_flag | output | 1 | Sticky droop flag |
| lvd_irq | output | 1 | Single-cycle droop interrupt request |
| nmi | output | 1 | Merged non-maskable interrupt |

## Verification
The software clear and a fresh filtered detection can land on the same clock edge. Their order decides whether a request escapes. The bench provokes this by holding the clear strobe high across the whole window in which the filter can fire. Every possible detection cycle therefore coincides with a clear. The result is judged by the flag reading 0 while the filtered level reads 0, and by the scoreboard seeing no request in that phase.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  // Number of selectable sample taps and log2 of the first divider stage.
  localparam int unsigned LVD_TAPS      = 4;
  localparam int unsigned LVD_FIRST_LOG = 3;
  localparam int unsigned LVD_SEL_W     = $clog2(LVD_TAPS);

  typedef enum logic [LVD_SEL_W-1:0] {
    RATE_DIV8  = 2'd0,
    RATE_DIV16 = 2'd1,
    RATE_DIV32 = 2'd2,
    RATE_DIV64 = 2'd3
  } lvd_rate_e;
endpackage

// File: rtl/lvd_prescaler.sv
module lvd_prescaler #(
  parameter int unsigned TAPS      = lvd_pkg::LVD_TAPS,
  parameter int unsigned FIRST_LOG = lvd_pkg::LVD_FIRST_LOG,
  localparam int unsigned SEL_W    = $clog2(TAPS),
  localparam int unsigned CNT_W    = FIRST_LOG + TAPS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             strobe
);
  logic [CNT_W-1:0] cnt_q;
  logic [TAPS-1:0]  tap;

  // Free-running chain: never gated, so sampling continues in sleep.
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // Tap i fires once every 2^(FIRST_LOG+i) clocks.
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap[i] = &cnt_q[FIRST_LOG-1+i:0];
  end

  always_ff @(posedge clk) begin
    if (rst) strobe <= 1'b0;
    else     strobe <= tap[sel];
  end

  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
endmodule

// File: rtl/lvd_filter.sv
module lvd_filter #(
  parameter int unsigned RUN   = 4,
  localparam int unsigned RUN_W = $clog2(RUN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic smp,
  input  logic din,
  output logic level_q,
  output logic fell_q
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      level_q <= 1'b1;
      run_q   <= '0;
      fell_q  <= 1'b0;
    end else begin
      fell_q <= 1'b0;
      if (smp) begin
        if (din == level_q) begin
          run_q <= '0;
        end else if (run_q == RUN_W'(RUN - 1)) begin
          level_q <= din;
          run_q   <= '0;
          fell_q  <= !din;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  // R2
  level_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_q) |-> ($past(smp) || !$past(en)));

  // R2
  fell_means_low_chk: assert property (@(posedge clk) disable iff (rst)
    fell_q |-> !level_q);
endmodule

// File: rtl/lvd_flag.sv
module lvd_flag (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic irq_en,
  input  logic clr,
  input  logic det,
  output logic flag_q,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= en && irq_en && det && !flag_q && !clr;
      if (!en || clr) flag_q <= 1'b0;
      else if (det)   flag_q <= 1'b1;
    end
  end

  // R3
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !flag_q);

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !flag_q && !irq_q);

  // R6
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q && !$past(flag_q) && $past(irq_en));

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
endmodule

// File: rtl/lvd_nmi_top.sv
module lvd_nmi_top #(
  parameter int unsigned TAPS      = lvd_pkg::LVD_TAPS,
  parameter int unsigned FIRST_LOG = lvd_pkg::LVD_FIRST_LOG,
  parameter int unsigned RUN       = 4,
  localparam int unsigned SEL_W    = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             det_on,
  input  logic             irq_on,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             flag_clr,
  input  logic             sup_ok,
  input  logic             wdt_req,
  input  logic             osc_req,
  output logic             lvd_level,
  output logic             lvd_flag,
  output logic             lvd_irq,
  output logic             nmi
);
  logic smp;
  logic fell;

  lvd_prescaler #(.TAPS(TAPS), .FIRST_LOG(FIRST_LOG)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .sel    (rate_sel),
    .strobe (smp)
  );

  lvd_filter #(.RUN(RUN)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .en      (det_on),
    .smp     (smp),
    .din     (sup_ok),
    .level_q (lvd_level),
    .fell_q  (fell)
  );

  lvd_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .en     (det_on),
    .irq_en (irq_on),
    .clr    (flag_clr),
    .det    (fell),
    .flag_q (lvd_flag),
    .irq_q  (lvd_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) nmi <= 1'b0;
    else     nmi <= lvd_irq | wdt_req | osc_req;
  end

  // R9
  ext_req_nmi_chk: assert property (@(posedge clk) disable iff (rst)
    (wdt_req || osc_req) |=> nmi);

  // R9
  lvd_req_nmi_chk: assert property (@(posedge clk) disable iff (rst)
    lvd_irq |=> nmi);

  // R3
  level_forced_chk: assert property (@(posedge clk) disable iff (rst)
    !det_on |=> lvd_level);
endmodule

// File: tb/lvd_nmi_top_test.sv
module lvd_nmi_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic det_on = 1'b0, irq_on = 1'b0, flag_clr = 1'b0;
  logic sup_ok = 1'b1, wdt_req = 1'b0, osc_req = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic lvd_level, lvd_flag, lvd_irq, nmi;

  int tests = 0, fails = 0;
  int irq_seen = 0, nmi_seen = 0;
  int exp_q[$];
  logic prev_lvd_irq = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lvd_nmi_top uut (
    .clk(clk), .rst(rst), .det_on(det_on), .irq_on(irq_on),
    .rate_sel(rate_sel), .flag_clr(flag_clr), .sup_ok(sup_ok),
    .wdt_req(wdt_req), .osc_req(osc_req), .lvd_level(lvd_level),
    .lvd_flag(lvd_flag), .lvd_irq(lvd_irq), .nmi(nmi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Driver side of the scoreboard: expected request count for a phase.
  task automatic expect_irq(input int k);
    exp_q.push_back(k);
    irq_seen = 0;
  endtask

  task automatic close_phase(input string req);
    int e;
    e = exp_q.pop_front();
    chk(irq_seen == e, req, irq_seen, e);
  endtask

  // Monitor: counts requests, and checks nmi follows each droop request (R9).
  always @(negedge clk) begin
    if (!rst) begin
      if (lvd_irq) irq_seen++;
      if (nmi) nmi_seen++;
      if (prev_lvd_irq) chk(nmi == 1'b1, "R9 nmi after lvd_irq", int'(nmi), 1);
      prev_lvd_irq = lvd_irq;
    end
  end

  task automatic settle_high(input int p);
    sup_ok = 1'b1;
    cyc(5 * p + 10);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    cyc(1);
    flag_clr = 1'b0;
    cyc(1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int per;
    int lat;
    cyc(5);
    // R10 reset state
    chk(lvd_level == 1'b1, "R10 level", int'(lvd_level), 1);
    chk(lvd_flag == 1'b0, "R10 flag", int'(lvd_flag), 0);
    chk(lvd_irq == 1'b0, "R10 irq", int'(lvd_irq), 0);
    chk(nmi == 1'b0, "R10 nmi", int'(nmi), 0);
    rst = 1'b0;
    cyc(2);
    det_on = 1'b1;
    irq_on = 1'b1;

    // R1/R2/R4/R6 for every rate
    for (int s = 0; s < 4; s++) begin
      rate_sel = 2'(s);
      per = 8 << s;
      settle_high(per);
      clear_flag();
      chk(lvd_flag == 1'b0, "R5 clear", int'(lvd_flag), 0);
      expect_irq(1);
      sup_ok = 1'b0;
      lat = 0;
      while (!lvd_flag && lat < 1000) begin
        cyc(1);
        lat++;
      end
      chk(lat >= 3 * per && lat <= 4 * per + 4, "R1 latency lower/upper", lat, 4 * per);
      chk(lvd_level == 1'b0, "R2 level low", int'(lvd_level), 0);
      cyc(4);
      close_phase("R6 single request");
      sup_ok = 1'b1;
      lat = 0;
      while (!lvd_level && lat < 1000) begin
        cyc(1);
        lat++;
      end
      chk(lat >= 3 * per && lat <= 4 * per + 4, "R2 rise latency", lat, 4 * per);
      chk(lvd_flag == 1'b1, "R4 flag sticky", int'(lvd_flag), 1);
    end

    // R7: another droop while flag set gives no request
    rate_sel = 2'd0;
    per = 8;
    expect_irq(0);
    nmi_seen = 0;
    sup_ok = 1'b0;
    cyc(6 * per);
    chk(lvd_level == 1'b0, "R7 level low", int'(lvd_level), 0);
    settle_high(per);
    close_phase("R7 no request");
    chk(nmi_seen == 0, "R7 no nmi", nmi_seen, 0);
    chk(lvd_flag == 1'b1, "R7 flag held", int'(lvd_flag), 1);

    // R2 glitch of two samples rejected
    clear_flag();
    sup_ok = 1'b0;
    cyc(2 * per);
    sup_ok = 1'b1;
    cyc(60);
    chk(lvd_flag == 1'b0, "R2 glitch flag", int'(lvd_flag), 0);
    chk(lvd_level == 1'b1, "R2 glitch level", int'(lvd_level), 1);

    // R6: interrupt disabled, flag still sets
    irq_on = 1'b0;
    expect_irq(0);
    sup_ok = 1'b0;
    cyc(5 * per + 10);
    chk(lvd_flag == 1'b1, "R6 flag without irq", int'(lvd_flag), 1);
    close_phase("R6 masked");

    // R3: disable forces level high, clears flag, blocks detection
    det_on = 1'b0;
    cyc(2);
    chk(lvd_level == 1'b1, "R3 level forced", int'(lvd_level), 1);
    chk(lvd_flag == 1'b0, "R3 flag cleared", int'(lvd_flag), 0);
    cyc(10 * per);
    chk(lvd_flag == 1'b0, "R3 no detect while off", int'(lvd_flag), 0);

    // R8: clear held across the detection window
    det_on = 1'b1;
    irq_on = 1'b1;
    settle_high(per);
    expect_irq(0);
    flag_clr = 1'b1;
    sup_ok = 1'b0;
    cyc(5 * per + 10);
    flag_clr = 1'b0;
    cyc(3);
    chk(lvd_level == 1'b0, "R8 level low", int'(lvd_level), 0);
    chk(lvd_flag == 1'b0, "R8 clear wins", int'(lvd_flag), 0);
    close_phase("R8 no request");

    // R5: after clear, a new droop requests again
    settle_high(per);
    expect_irq(1);
    sup_ok = 1'b0;
    cyc(5 * per + 10);
    chk(lvd_flag == 1'b1, "R5 flag again", int'(lvd_flag), 1);
    close_phase("R5 request again");
    settle_high(per);

    // R9: external sources
    nmi_seen = 0;
    wdt_req = 1'b1;
    cyc(1);
    wdt_req = 1'b0;
    cyc(3);
    chk(nmi_seen == 1, "R9 wdt", nmi_seen, 1);
    nmi_seen = 0;
    osc_req = 1'b1;
    cyc(1);
    osc_req = 1'b0;
    cyc(3);
    chk(nmi_seen == 1, "R9 osc", nmi_seen, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule